// File: doc/BRIEF.md
# Mode-Multiplexed Bidirectional I/O Port

This block is an 8-bit bidirectional pin port for a microcontroller. Software reaches it through a small register bus with four registers: a data latch, a direction mask, a per-pin pull-up mask and a control register. The control register holds an open-drain enable. The outputs are per-pin pad controls: drive value, push-pull output enable, open-drain low-drive and pull-up enable.

A strap input gives the chip operating mode. In single-chip and bootstrap modes the port owns the pads as general-purpose pins. In expanded and test modes the pads carry the external data bus. In that case the bus write strobe and the bus data path drive them, and the direction mask is ignored.

Pin levels pass through a two-stage synchronizer before software or the bus can see them. Reading the data register returns, for each pin, the synchronized pin level when the pin is an input and the latched drive value when it is an output. Setting the open-drain bit makes output pins wired-OR style: a latched 0 pulls the pin low and a latched 1 leaves it floating. This option works only in single-chip mode.

Top module: `mxport`

## Requirements
- R1: After reset the data latch, direction mask, pull-up mask and open-drain bit are all zero. In single-chip and bootstrap modes no pad is driven: the output enable and low-drive are zero.
- R2: A write to the data register (select 0) always updates the latch, whatever the direction mask holds. When a pin is later made an output, the value read back is the value written earlier.
- R3: Reading select 0 returns, per bit, the latch where the direction bit is 1. Where the direction bit is 0 it returns the pad input as it was two rising clock edges earlier.
- R4: In general-purpose modes (mode 00 single-chip, mode 10 bootstrap) with open-drain inactive, the output enable equals the direction mask and the pad output equals the latch.
- R5: In bus modes (mode 01 expanded, mode 11 test), every output enable bit equals the bus write strobe and the pad output equals the bus write data. The direction mask has no effect, low-drive stays zero, and the bus read data is the two-edge-synchronized pad input.
- R6: In single-chip mode with the open-drain bit (select 3, bit 0) set, a direction-1 pin with latch 0 has low-drive 1 and output enable 0. A direction-1 pin with latch 1 has both at 0, so the pin floats.
- R7: The open-drain bit has no effect in bootstrap, expanded or test mode. Pads there behave as in R4 or R5, and low-drive stays zero.
- R8: The pull-up enable of each pad equals the matching bit of the pull-up register (select 2) in every mode. Reading select 2 returns that register.
- R9: Writes take effect at the rising edge where the write enable is high and are visible on the next cycle. Select 1 reads back the direction mask. Select 3 reads back the open-drain bit in bit 0 and zeros in the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode strap: 00 single-chip, 01 expanded, 10 bootstrap, 11 test |
| reg_sel_i | input | 2 | Register select: 0 data, 1 direction, 2 pull-up, 3 control |
| reg_wr_i | input | 1 | Register write enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the current select |
| bus_wr_i | input | 1 | External bus write strobe (bus modes) |
| bus_wdata_i | input | 8 | External bus write data (bus modes) |
| bus_rdata_o | output | 8 | Synchronized pad levels for the bus read path |
| pad_in_i | input | 8 | Pad input levels |
| pad_out_o | output | 8 | Pad drive value |
| pad_oe_o | output | 8 | Push-pull output enable per pad |
| pad_od_low_o | output | 8 | Open-drain pull-low enable per pad |
| pad_pu_o | output | 8 | Pull-up enable per pad |

## Verification
The bench checks read-back timing on mixed direction masks. A design that returns the pad level for output pins, or that skips a synchronizer stage, produces a read one cycle early or the wrong source for some bits. It sets the open-drain bit in each of the four modes. A design that honours it outside single-chip mode shows a missing output enable or a spurious low-drive, and one that mixes up latch polarity pulls a pin low that should float. In bus modes it changes the direction mask and toggles the strobe, which exposes a design that lets the mask leak into the output enable. It also writes the latch while every pin is an input, then turns the pins into outputs, which catches a latch gated by direction.

// File: rtl/mxport_pkg.sv
package mxport_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } op_mode_e;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PULL = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  localparam int CTRL_OD_BIT = 0;

  // port owns the pads as general-purpose pins
  function automatic logic gp_owner(input logic [1:0] mode);
    return (mode == MODE_SINGLE) || (mode == MODE_BOOT);
  endfunction

  // open-drain bit honoured only in single-chip mode
  function automatic logic od_effective(input logic [1:0] mode, input logic od_bit);
    return od_bit && (mode == MODE_SINGLE);
  endfunction

endpackage

// File: rtl/mxport_sync.sv
module mxport_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

  // two-edge history qualifier for the latency check
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  a_r3_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2) |-> (sync_o == $past(async_i, 2)));

endmodule

// File: rtl/mxport_regs.sv
module mxport_regs
  import mxport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] pin_sync_i,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] pull_o,
  output logic             od_o,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] latch_q, dir_q, pull_q;
  logic             od_q;

  // per-bit choice between driver latch and observed pin
  function automatic logic [WIDTH-1:0] readback(input logic [WIDTH-1:0] dir,
                                                input logic [WIDTH-1:0] lat,
                                                input logic [WIDTH-1:0] pin);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = dir[i] ? lat[i] : pin[i];
    return r;
  endfunction

  logic wr_data, wr_dir, wr_pull, wr_ctrl;
  assign wr_data = wr_i && (sel_i == SEL_DATA);
  assign wr_dir  = wr_i && (sel_i == SEL_DIR);
  assign wr_pull = wr_i && (sel_i == SEL_PULL);
  assign wr_ctrl = wr_i && (sel_i == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      pull_q  <= '0;
      od_q    <= 1'b0;
    end else begin
      if (wr_data) latch_q <= wdata_i;
      if (wr_dir)  dir_q   <= wdata_i;
      if (wr_pull) pull_q  <= wdata_i;
      if (wr_ctrl) od_q    <= wdata_i[CTRL_OD_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_DATA: rdata_o = readback(dir_q, latch_q, pin_sync_i);
      SEL_DIR:  rdata_o = dir_q;
      SEL_PULL: rdata_o = pull_q;
      SEL_CTRL: rdata_o[CTRL_OD_BIT] = od_q;
      default:  rdata_o = '0;
    endcase
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;
  assign pull_o  = pull_q;
  assign od_o    = od_q;

  a_r2_latch_ignores_dir: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (latch_o == $past(wdata_i)));

  a_r9_dir_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_o));

  a_r9_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == SEL_CTRL) |-> (rdata_o[WIDTH-1:1] == '0));

endmodule

// File: rtl/mxport_padctl.sv
module mxport_padctl
  import mxport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [WIDTH-1:0] latch_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] pull_i,
  input  logic             od_i,
  input  logic             bus_wr_i,
  input  logic [WIDTH-1:0] bus_wdata_i,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pad_od_low_o,
  output logic [WIDTH-1:0] pad_pu_o
);

  logic gp_mode;
  logic od_on;
  assign gp_mode = gp_owner(mode_i);
  assign od_on   = od_effective(mode_i, od_i);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      if (gp_mode) begin
        pad_out_o[i]    = latch_i[i];
        pad_oe_o[i]     = dir_i[i] && !od_on;
        pad_od_low_o[i] = dir_i[i] && od_on && !latch_i[i];
      end else begin
        pad_out_o[i]    = bus_wdata_i[i];
        pad_oe_o[i]     = bus_wr_i;
        pad_od_low_o[i] = 1'b0;
      end
    end
  end

  assign pad_pu_o = pull_i;

  a_r6_no_drive_fight: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe_o & pad_od_low_o) == '0);

  a_r5_bus_ignores_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !gp_mode |-> (pad_oe_o == {WIDTH{bus_wr_i}}) && (pad_od_low_o == '0));

  a_r7_od_single_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_SINGLE) |-> (pad_od_low_o == '0));

  a_r4_gp_latch_drive: assert property (@(posedge clk) disable iff (!rst_n)
    gp_mode |-> (pad_out_o == latch_i));

endmodule

// File: rtl/mxport.sv
module mxport
  import mxport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       reg_sel_i,
  input  logic             reg_wr_i,
  input  logic [WIDTH-1:0] reg_wdata_i,
  output logic [WIDTH-1:0] reg_rdata_o,
  input  logic             bus_wr_i,
  input  logic [WIDTH-1:0] bus_wdata_i,
  output logic [WIDTH-1:0] bus_rdata_o,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pad_od_low_o,
  output logic [WIDTH-1:0] pad_pu_o
);

  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] latch_w, dir_w, pull_w;
  logic             od_w;

  mxport_sync #(.WIDTH(WIDTH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pad_in_i),
    .sync_o  (pin_sync)
  );

  mxport_regs #(.WIDTH(WIDTH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (reg_sel_i),
    .wr_i       (reg_wr_i),
    .wdata_i    (reg_wdata_i),
    .pin_sync_i (pin_sync),
    .latch_o    (latch_w),
    .dir_o      (dir_w),
    .pull_o     (pull_w),
    .od_o       (od_w),
    .rdata_o    (reg_rdata_o)
  );

  mxport_padctl #(.WIDTH(WIDTH)) u_padctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .latch_i      (latch_w),
    .dir_i        (dir_w),
    .pull_i       (pull_w),
    .od_i         (od_w),
    .bus_wr_i     (bus_wr_i),
    .bus_wdata_i  (bus_wdata_i),
    .pad_out_o    (pad_out_o),
    .pad_oe_o     (pad_oe_o),
    .pad_od_low_o (pad_od_low_o),
    .pad_pu_o     (pad_pu_o)
  );

  assign bus_rdata_o = pin_sync;

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && gp_owner(mode_i)) |-> (pad_oe_o == '0) && (pad_od_low_o == '0));

endmodule

// File: tb/mxport_bench.sv
module mxport_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [1:0]   sel = 2'd0;
  logic         wr = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         bus_wr = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out, pad_oe, pad_odl, pad_pu;

  mxport #(.WIDTH(W)) u_mxport (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .reg_sel_i(sel), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .pad_od_low_o(pad_odl), .pad_pu_o(pad_pu)
  );

  int errors = 0;
  int checks = 0;
  bit cmp_en = 1'b0;

  // behavioural reference state
  logic [W-1:0] m_data, m_dir, m_pull;
  logic         m_od;
  logic [W-1:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = '0; m_dir = '0; m_pull = '0; m_od = 1'b0;
      hist = {'0, '0};
    end else begin
      if (wr) begin
        if (sel == 2'd0) m_data = wdata;
        else if (sel == 2'd1) m_dir = wdata;
        else if (sel == 2'd2) m_pull = wdata;
        else m_od = wdata[0];
      end
      hist.push_back(pad_in);
      void'(hist.pop_front());
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit gp, od;
    logic [W-1:0] e_out, e_oe, e_odl, e_rd;
    gp = (mode == 2'b00) || (mode == 2'b10);
    od = m_od && (mode == 2'b00);
    e_out = gp ? m_data : bus_wdata;
    e_oe  = gp ? (od ? '0 : m_dir) : {W{bus_wr}};
    e_odl = (gp && od) ? (m_dir & ~m_data) : '0;
    chk(gp ? "R4" : "R5", "pad_out", pad_out, e_out);
    chk(od ? "R6" : (m_od ? "R7" : (gp ? "R4" : "R5")), "pad_oe", pad_oe, e_oe);
    chk(od ? "R6" : "R7", "pad_od_low", pad_odl, e_odl);
    chk("R8", "pad_pu", pad_pu, m_pull);
    chk("R5", "bus_rdata", bus_rdata, hist[0]);
    case (sel)
      2'd0: begin e_rd = (m_dir & m_data) | (~m_dir & hist[0]); chk("R3", "rdata data", rdata, e_rd); end
      2'd1: chk("R9", "rdata dir", rdata, m_dir);
      2'd2: chk("R8", "rdata pull", rdata, m_pull);
      default: begin e_rd = '0; e_rd[0] = m_od; chk("R9", "rdata ctrl", rdata, e_rd); end
    endcase
  endtask

  always @(negedge clk) if (cmp_en) compare_all();

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic write_reg(input logic [1:0] s, input logic [W-1:0] v);
    sel = s; wdata = v; wr = 1'b1;
    step();
    wr = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] m);
    step();
    cmp_en = 1'b0;
    rst_n = 1'b0; mode = m; wr = 1'b0; bus_wr = 1'b0;
    step(); step();
    rst_n = 1'b1;
    #1;
    // R1 reset state, checked at the ports
    sel = 2'd1; #1; chk("R1", "dir after reset", rdata, '0);
    sel = 2'd2; #1; chk("R1", "pull after reset", rdata, '0);
    sel = 2'd3; #1; chk("R1", "ctrl after reset", rdata, '0);
    if (m == 2'b00 || m == 2'b10) begin
      chk("R1", "oe after reset", pad_oe, '0);
      chk("R1", "od_low after reset", pad_odl, '0);
      chk("R1", "latch after reset", pad_out, '0);
    end
    cmp_en = 1'b1;
  endtask

  task automatic random_run(input int n);
    for (int k = 0; k < n; k++) begin
      pad_in = W'($urandom);
      bus_wr = 1'($urandom);
      bus_wdata = W'($urandom);
      sel = 2'($urandom);
      wdata = W'($urandom);
      wr = ($urandom % 3) == 0;
      step();
      wr = 1'b0;
    end
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // single-chip mode
    do_reset(2'b00);
    pad_in = 8'h3C;
    write_reg(2'd0, 8'hA5);          // R2: written while all pins are inputs
    step(); step();
    sel = 2'd0; #1;
    chk("R3", "input pins read pad", rdata, 8'h3C);
    write_reg(2'd1, 8'hFF);
    sel = 2'd0; #1;
    chk("R2", "latched value after dir change", rdata, 8'hA5);
    chk("R4", "oe follows dir", pad_oe, 8'hFF);

    // R3 mixed direction and synchronizer latency
    write_reg(2'd1, 8'h0F);
    pad_in = 8'h00; step(); step(); step();
    sel = 2'd0;
    pad_in = 8'hF0;
    step(); #1;
    chk("R3", "one edge: old pin value", rdata, 8'h05);
    step(); #1;
    chk("R3", "two edges: new pin value", rdata, 8'hF5);

    // R8 pull-ups
    write_reg(2'd2, 8'h96);
    #1; chk("R8", "pull-up pads", pad_pu, 8'h96);

    // R6 open-drain in single-chip
    write_reg(2'd1, 8'hFF);
    write_reg(2'd0, 8'hC3);
    write_reg(2'd3, 8'hFF);
    #1;
    chk("R6", "od low on latch 0", pad_odl, 8'h3C);
    chk("R6", "no push-pull under od", pad_oe, 8'h00);
    sel = 2'd3; #1; chk("R9", "ctrl readback bit0 only", rdata, 8'h01);
    random_run(200);

    // R7 bootstrap: od ignored
    do_reset(2'b10);
    write_reg(2'd1, 8'h5A);
    write_reg(2'd0, 8'h00);
    write_reg(2'd3, 8'h01);
    #1;
    chk("R7", "boot push-pull under od", pad_oe, 8'h5A);
    chk("R7", "boot no low-drive", pad_odl, 8'h00);
    random_run(200);

    // R5 expanded: bus owns pads
    do_reset(2'b01);
    write_reg(2'd1, 8'hFF);
    write_reg(2'd3, 8'h01);
    bus_wdata = 8'h69; bus_wr = 1'b0; #1;
    chk("R5", "bus idle oe", pad_oe, 8'h00);
    bus_wr = 1'b1; #1;
    chk("R5", "bus write oe", pad_oe, 8'hFF);
    chk("R5", "bus write data", pad_out, 8'h69);
    chk("R7", "expanded no low-drive", pad_odl, 8'h00);
    random_run(200);

    // test mode
    do_reset(2'b11);
    random_run(200);

    step();
    cmp_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule